// File: doc/BRIEF.md
# Transmit Link Phase and Ready Controller

This block follows the bring-up phases of a multi-lane serial converter transmit link and turns them into the flags the upstream data source acts on. It runs in the link clock domain. On every cycle each lane moves one 32-bit word of four octets, packed big-endian: the first octet is in bits [31:24] and the last is in bits [7:0]. Lane 0 takes the least significant word of a wide bus, and lane n takes bits [32n+31:32n]. Three phases follow one another. Code-group synchronisation lasts while the receiver holds its active-low synchronisation request. Initial lane alignment then lasts exactly four multiframes. User data follows the alignment phase.

There are two ready outputs, and they open at different points. Frame-ready rises when the fourth alignment multiframe begins, so the transport layer can prime its pipeline. Link-ready rises only when user data begins. Both have a ready latency of zero, and the sink never applies back-pressure. On every cycle that link-ready is high, the source must present valid data, and that word is consumed. The source may not stall the stream, and the block has no way to refuse a word while link-ready is high. A 4-bit start-of-multiframe vector marks which octet position of the current word begins a multiframe. Bit 3 refers to bits [31:24] and bit 0 refers to bits [7:0].

The frame length and the multiframe length are run-time inputs. The block samples them throughout the synchronisation phase, so they may change safely only while a synchronisation request is held.

Top module: `tx_link_phase_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, link_ready and frame_ready are 0 and sof_mf is 4'b0000.
- R2: When sync_req_n is sampled low at a clock edge, the block is in the synchronisation phase from that edge on. Both ready flags are 0 and sof_mf is 0 for as long as the request is held.
- R3: The edge that samples sync_req_n high during the synchronisation phase starts the alignment phase. On the cycle that follows, sof_mf is 4'b1000.
- R4: The alignment phase lasts exactly 4·W cycles, where W = F·K/4. frame_ready is high only during its last W cycles, and link_ready stays 0 throughout it.
- R5: After the alignment phase, link_ready and frame_ready are both 1 on every cycle until the next synchronisation request.
- R6: During alignment and user data, sof_mf bit 3 (the octet in bits [31:24]) is 1 exactly on the first cycle of each W-cycle multiframe. Bits 2:0 stay 0, because F·K is a multiple of 4.
- R7: The frame parameters are encoded as cfg_f = F−1 and cfg_k = K−1. They are captured on every synchronisation-phase cycle, and a change while not in that phase has no effect until the next synchronisation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req_n | input | 1 | Active-low synchronisation request from the receiver |
| cfg_f | input | 8 | Octets per frame minus one |
| cfg_k | input | 5 | Frames per multiframe minus one |
| link_ready | output | 1 | Sink accepts user data this cycle (zero latency, no back-pressure) |
| frame_ready | output | 1 | Transport layer may start feeding data (last alignment multiframe onward) |
| sof_mf | output | 4 | Start-of-multiframe flag per octet position, bit 3 = bits [31:24] |

## Verification
The bench uses the default widths: an 8-bit frame field, a 5-bit multiframe field and four octets per word. It runs through F·K values of 4, 8, 16 and 128. These give multiframes of one, two, four and thirty-two words, so the bench covers the case where every cycle starts a multiframe, the short and mid-sized cases, and a long alignment phase that a sync request interrupts part-way through. Parameter changes made during user data and during alignment show that the captured length stays in force until the next synchronisation phase.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_ALIGN = 2'd1,
    PH_DATA  = 2'd2
  } tlp_phase_e;
endpackage

// File: rtl/tlp_cfg_hold.sv
module tlp_cfg_hold #(
  parameter int F_W    = 8,
  parameter int K_W    = 5,
  parameter int OCT_SH = 2,
  localparam int FK_W  = F_W + K_W + 1,
  localparam int WC_W  = FK_W - OCT_SH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [F_W-1:0]  cfg_f,
  input  logic [K_W-1:0]  cfg_k,
  output logic [WC_W-1:0] wpm_last
);
  logic [FK_W-1:0] fk_c;
  logic [WC_W-1:0] words_c;

  always_comb begin
    fk_c    = (FK_W'(cfg_f) + FK_W'(1)) * (FK_W'(cfg_k) + FK_W'(1));
    words_c = fk_c[FK_W-1:OCT_SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wpm_last <= '0;
    else if (capture) wpm_last <= words_c - WC_W'(1);
  end

  // R6
  fk_mult4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (fk_c[OCT_SH-1:0] == '0 && words_c != '0));
endmodule

// File: rtl/tlp_mf_counter.sv
module tlp_mf_counter #(
  parameter int WC_W    = 12,
  parameter int ILAS_MF = 4,
  localparam int MF_W   = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [WC_W-1:0] wpm_last,
  output logic [WC_W-1:0] word_idx,
  output logic [MF_W-1:0] mf_idx,
  output logic            last_mf,
  output logic            align_done
);
  localparam logic [MF_W-1:0] MF_LAST = MF_W'(ILAS_MF - 1);
  logic mf_wrap;

  always_comb begin
    mf_wrap    = (word_idx == wpm_last);
    last_mf    = (mf_idx == MF_LAST);
    align_done = mf_wrap && last_mf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_idx <= '0;
      mf_idx   <= '0;
    end else if (!run) begin
      word_idx <= '0;
      mf_idx   <= '0;
    end else if (mf_wrap) begin
      word_idx <= '0;
      if (!last_mf) mf_idx <= mf_idx + MF_W'(1);
    end else begin
      word_idx <= word_idx + WC_W'(1);
    end
  end

  // R6
  word_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> word_idx <= wpm_last);
  // R4
  mf_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !mf_wrap |=> $stable(mf_idx) || !$past(run));
endmodule

// File: rtl/tlp_phase_fsm.sv
module tlp_phase_fsm
  import tlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_req_n,
  input  logic       align_done,
  output tlp_phase_e phase
);
  tlp_phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    if (!sync_req_n) begin
      phase_nx = PH_SYNC;
    end else begin
      case (phase)
        PH_SYNC:  phase_nx = PH_ALIGN;
        PH_ALIGN: if (align_done) phase_nx = PH_DATA;
        PH_DATA:  phase_nx = PH_DATA;
        default:  phase_nx = PH_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_SYNC;
    else        phase <= phase_nx;
  end

  // R5
  data_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DATA |=> phase != PH_ALIGN);
  // R3
  sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SYNC && sync_req_n |=> phase == PH_ALIGN);
endmodule

// File: rtl/tlp_flag_gen.sv
module tlp_flag_gen
  import tlp_pkg::*;
#(
  parameter int WC_W    = 12,
  parameter int OPW     = 4,
  parameter int MF_W    = 2,
  localparam int OCT_SH = $clog2(OPW)
) (
  input  tlp_phase_e      phase,
  input  logic [WC_W-1:0] word_idx,
  input  logic            last_mf,
  output logic            link_ready,
  output logic            frame_ready,
  output logic [OPW-1:0]  sof_mf
);
  logic active;

  always_comb begin
    active      = (phase != PH_SYNC);
    link_ready  = (phase == PH_DATA);
    frame_ready = link_ready || (phase == PH_ALIGN && last_mf);
  end

  // Octet position p counts from the first octet (MSB side) of the word.
  for (genvar p = 0; p < OPW; p++) begin : g_oct
    logic [WC_W+OCT_SH-1:0] oct_off;
    always_comb begin
      oct_off            = {word_idx, OCT_SH'(p)};
      sof_mf[OPW-1-p]    = active && (oct_off == '0);
    end
  end
endmodule

// File: rtl/tx_link_phase_ctrl.sv
module tx_link_phase_ctrl
  import tlp_pkg::*;
#(
  parameter int F_W     = 8,
  parameter int K_W     = 5,
  parameter int OPW     = 4,
  parameter int ILAS_MF = 4,
  localparam int OCT_SH = $clog2(OPW),
  localparam int FK_W   = F_W + K_W + 1,
  localparam int WC_W   = FK_W - OCT_SH,
  localparam int MF_W   = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_req_n,
  input  logic [F_W-1:0] cfg_f,
  input  logic [K_W-1:0] cfg_k,
  output logic           link_ready,
  output logic           frame_ready,
  output logic [OPW-1:0] sof_mf
);
  tlp_phase_e      phase;
  logic [WC_W-1:0] wpm_last;
  logic [WC_W-1:0] word_idx;
  logic [MF_W-1:0] mf_idx;
  logic            last_mf;
  logic            align_done;

  tlp_cfg_hold #(.F_W(F_W), .K_W(K_W), .OCT_SH(OCT_SH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(phase == PH_SYNC),
    .cfg_f(cfg_f), .cfg_k(cfg_k), .wpm_last(wpm_last)
  );

  tlp_mf_counter #(.WC_W(WC_W), .ILAS_MF(ILAS_MF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(phase != PH_SYNC), .wpm_last(wpm_last),
    .word_idx(word_idx), .mf_idx(mf_idx), .last_mf(last_mf),
    .align_done(align_done)
  );

  tlp_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n),
    .align_done(align_done), .phase(phase)
  );

  tlp_flag_gen #(.WC_W(WC_W), .OPW(OPW), .MF_W(MF_W)) u_flags (
    .phase(phase), .word_idx(word_idx), .last_mf(last_mf),
    .link_ready(link_ready), .frame_ready(frame_ready), .sof_mf(sof_mf)
  );

  // R2
  sync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req_n |=> !link_ready && !frame_ready && sof_mf == '0);
  // R5
  link_implies_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> frame_ready);
  // R4
  frame_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ready) && !link_ready |-> sof_mf[OPW-1]);
  // R6
  one_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sof_mf) <= 1);
  // R7
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_SYNC && $past(phase) != PH_SYNC |-> $stable(wpm_last));
endmodule

// File: tb/tx_link_phase_ctrl_tb.sv
module tx_link_phase_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_req_n = 1'b0;
  logic [7:0] cfg_f = 8'd1;
  logic [4:0] cfg_k = 5'd3;
  logic       link_ready, frame_ready;
  logic [3:0] sof_mf;

  int n_tests = 0;
  int n_fail  = 0;
  bit r7_win  = 1'b0;

  always #2.5 clk = ~clk;

  tx_link_phase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n),
    .cfg_f(cfg_f), .cfg_k(cfg_k),
    .link_ready(link_ready), .frame_ready(frame_ready), .sof_mf(sof_mf)
  );

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endfunction

  // Behavioural reference: phase 0 sync, 1 align, 2 data; pos = cycles into phase.
  int m_ph = 0, m_pos = 0, m_w = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pos = 0;
    end else begin
      if (m_ph == 0) m_w = ((int'(cfg_f) + 1) * (int'(cfg_k) + 1)) / 4;
      if (!sync_req_n) begin
        m_ph = 0; m_pos = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_pos = 0;
      end else if (m_ph == 1) begin
        if (m_pos == 4 * m_w - 1) begin m_ph = 2; m_pos = 0; end
        else m_pos++;
      end else begin
        m_pos = (m_pos + 1) % m_w;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_lr, e_fr;
      logic [3:0] e_sof;
      string tf, ts;
      e_lr  = (m_ph == 2);
      e_fr  = (m_ph == 2) || (m_ph == 1 && m_pos >= 3 * m_w);
      e_sof = (m_ph != 0 && (m_pos % m_w) == 0) ? 4'b1000 : 4'b0000;
      tf = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R4" : "R5";
      ts = (m_ph == 1 && m_pos == 0) ? "R3" : (m_ph == 0) ? "R2" : "R6";
      if (r7_win) begin tf = "R7"; ts = "R7"; end
      chk(link_ready == e_lr, tf, "link_ready", int'(link_ready), int'(e_lr));
      chk(frame_ready == e_fr, tf, "frame_ready", int'(frame_ready), int'(e_fr));
      chk(sof_mf == e_sof, ts, "sof_mf", int'(sof_mf), int'(e_sof));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Release the request and count negedges until link_ready (one sync-phase negedge included).
  task automatic measure(int exp_cycles, string tag);
    int cnt = 0;
    sync_req_n = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (link_ready) break;
      cnt++;
    end
    chk(cnt == exp_cycles, tag, "cycles to link_ready", cnt, exp_cycles);
    #1;
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, F=2 K=4 -> W=2
    tick(3);
    chk(link_ready == 1'b0, "R1", "link_ready in reset", int'(link_ready), 0);
    chk(frame_ready == 1'b0, "R1", "frame_ready in reset", int'(frame_ready), 0);
    chk(sof_mf == 4'b0000, "R1", "sof_mf in reset", int'(sof_mf), 0);
    rst_n = 1'b1;
    tick(1);
    chk(link_ready == 1'b0 && frame_ready == 1'b0, "R1", "flags after reset",
        int'({link_ready, frame_ready}), 0);
    tick(3);
    measure(4 * 2 + 1, "R4");
    tick(10);
    // R2: single-cycle request during user data
    sync_req_n = 1'b0;
    tick(1);
    chk(link_ready == 1'b0 && frame_ready == 1'b0, "R2", "flags after request",
        int'({link_ready, frame_ready}), 0);
    sync_req_n = 1'b1;
    tick(20);
    // R7: new length during user data must be ignored (F=1 K=4 -> W=1)
    r7_win = 1'b1;
    cfg_f = 8'd0; cfg_k = 5'd3;
    tick(12);
    r7_win = 1'b0;
    sync_req_n = 1'b0;
    tick(3);
    measure(4 * 1 + 1, "R7");
    tick(8);
    // R2: request part-way through a long alignment (F=4 K=32 -> W=32)
    cfg_f = 8'd3; cfg_k = 5'd31;
    sync_req_n = 1'b0;
    tick(2);
    sync_req_n = 1'b1;
    tick(50);
    sync_req_n = 1'b0;
    tick(1);
    chk(frame_ready == 1'b0 && sof_mf == 4'b0000, "R2", "mid-align request",
        int'({frame_ready, sof_mf}), 0);
    tick(2);
    measure(4 * 32 + 1, "R4");
    tick(70);
    // R6/R7: F=8 K=2 -> W=4, change during alignment is ignored
    cfg_f = 8'd7; cfg_k = 5'd1;
    sync_req_n = 1'b0;
    tick(2);
    sync_req_n = 1'b1;
    tick(3);
    r7_win = 1'b1;
    cfg_f = 8'd0; cfg_k = 5'd3;
    tick(40);
    r7_win = 1'b0;
    chk(link_ready == 1'b1, "R5", "link_ready in user data", int'(link_ready), 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule